// File: doc/BRIEF.md
# Basic Interval Timer

The block is a free-running 8-bit interval counter that advances once per tick of one of four prescaled taps of the system clock. Every time the counter wraps from its all-ones value back to zero it raises an interrupt request flag, which stays set until software clears it. The same wrap event toggles a clock output pin, so the pin carries a square wave tied to the chosen interval.

Software programs the timer through a small mode write: a two-bit interval selection and a clear bit. Writing with the clear bit set zeroes the counter and the prescaler in one cycle and loads the new interval selection, so the first interval after a clear always has its full length. A write without the clear bit changes nothing.

After every reset, including a reset taken while the chip is in a power-down mode, the block counts an oscillation-stabilization delay of 2^17 system clocks (256 counts of the divide-by-512 tap). It holds its CPU-run enable low for that time and then drives it high for good.

Top module: `interval_timer`

## Requirements
- R1: While reset is low and in the cycle after its release, the interrupt flag, the clock output and the CPU-run enable are all 0; the interval selection returns to code 0.
- R2: The interval selection code picks the tick divisor of the counter: code 0 divides the system clock by 2^13, code 1 by 2^10, code 2 by 2^8, code 3 by 2^6.
- R3: With no intervening clear, the interrupt flag is set at exactly every 256 x divisor system-clock edges counted from the last reset release or clear write.
- R4: A mode write with the clear bit set restarts both the prescaler and the counter, so the next interrupt comes a full 256 x divisor edges after that write.
- R5: The clock output toggles on every counter wrap and at no other time.
- R6: The CPU-run enable stays 0 for the first 2^17 clock edges after reset release, becomes 1 at that edge, and stays 1 until the next reset.
- R7: A mode write with the clear bit at 0 has no effect on timing; a new interval selection takes effect only with a clear write.
- R8: An interrupt clear pulse drops the interrupt flag on the next edge.
- R9: When a counter wrap and an interrupt clear fall in the same cycle, the flag ends up set.
- R10: A reset asserted during operation restarts the stabilization wait and returns the CPU-run enable to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| mode_we_i | input | 1 | Mode write strobe, one cycle |
| mode_sel_i | input | 2 | Interval selection code written with the strobe |
| mode_clr_i | input | 1 | Clear bit written with the strobe |
| irq_clr_i | input | 1 | Software clear of the interrupt flag |
| irq_o | output | 1 | Interrupt request flag |
| clk_out_o | output | 1 | Square-wave clock output, toggles on each wrap |
| cpu_run_o | output | 1 | CPU-run enable, high once stabilization has elapsed |

## Verification
The bench runs each of the four interval codes from a clear write for more than two periods, which tells a wrong tap or an off-by-one prescaler apart by the exact edge of every wrap. Mode writes without the clear bit and with a changed code show that the running interval is left alone, while interrupt clears held across a wrap separate a set-wins flag from a clear-wins one. A long stretch of random mode writes, clears and interrupt clears, plus a reset in mid-run, is followed edge by edge by a bench model built on elapsed-cycle counting rather than on a counter copy.

// File: rtl/interval_timer_pkg.sv
// Shared types and helpers for the interval timer.
// Assumes exactly four prescaler taps selected by a two-bit code.
package interval_timer_pkg;

    localparam int unsigned NUM_TAPS = 4;

    typedef logic [1:0] tap_sel_t;

    // Largest of four exponents; sizes the shared prescaler.
    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/interval_timer_presc.sv
// Free-running prescaler with four divide taps.
// Each tap pulses tick for one cycle when its low EXP bits are all ones,
// giving one tick every 2^EXP clocks. A clear zeroes the prescaler.
// Assumes every exponent is at least 1.
module interval_timer_presc
    import interval_timer_pkg::*;
#(
    parameter int unsigned EXP0 = 13,
    parameter int unsigned EXP1 = 10,
    parameter int unsigned EXP2 = 8,
    parameter int unsigned EXP3 = 6
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     clr_i,
    input  tap_sel_t sel_i,
    output logic     tick_o
);

    localparam int unsigned PRE_W = max4(EXP0, EXP1, EXP2, EXP3);
    localparam int unsigned EXPS [NUM_TAPS] = '{EXP0, EXP1, EXP2, EXP3};

    logic [PRE_W-1:0]    pre_q;
    logic [NUM_TAPS-1:0] tap_hit;

    // Prescaler advance; reset and clear both restart it at zero.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clr_i) pre_q <= '0;
        else                  pre_q <= pre_q + 1'b1;
    end

    // One all-ones detector per tap.
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        assign tap_hit[g] = &pre_q[EXPS[g]-1:0];
    end

    // Tap multiplexer.
    always_comb tick_o = tap_hit[sel_i];

endmodule

// File: rtl/interval_timer_cnt.sv
// Interval counter: advances on each tick and flags a wrap when a tick
// arrives at the all-ones value. Clear has priority over counting and
// suppresses the wrap flag in that cycle.
module interval_timer_cnt #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count ticks; wraps naturally from all ones to zero.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clr_i) cnt_q <= '0;
        else if (tick_i)      cnt_q <= cnt_q + 1'b1;
    end

    // Wrap event for the interrupt flag and the clock output.
    always_comb wrap_o = tick_i && (&cnt_q) && !clr_i;

    assign cnt_o = cnt_q;

endmodule

// File: rtl/interval_timer_stab.sv
// Stabilization wait: counts 2^(STAB_EXP+CNT_W) clocks after reset,
// then raises the run enable and holds it until the next reset.
module interval_timer_stab #(
    parameter int unsigned STAB_EXP = 9,
    parameter int unsigned CNT_W    = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic run_o
);

    localparam int unsigned WAIT_W = STAB_EXP + CNT_W;

    logic [WAIT_W-1:0] wait_q;
    logic              run_q;

    // Wait counter; stops once the enable is up.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     wait_q <= '0;
        else if (!run_q) wait_q <= wait_q + 1'b1;
    end

    // Enable goes high on the edge that completes the wait.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)          run_q <= 1'b0;
        else if (&wait_q)     run_q <= 1'b1;
    end

    assign run_o = run_q;

endmodule

// File: rtl/interval_timer_out.sv
// Interrupt flag and square-wave output. The flag is set by a wrap and
// cleared by software; a wrap in the same cycle wins. The output pin
// toggles on each wrap.
module interval_timer_out (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wrap_i,
    input  logic irq_clr_i,
    output logic irq_o,
    output logic clk_out_o
);

    logic irq_q;
    logic pin_q;

    // Interrupt request flag, set priority.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        irq_q <= 1'b0;
        else if (wrap_i)    irq_q <= 1'b1;
        else if (irq_clr_i) irq_q <= 1'b0;
    end

    // Output pin toggle on wrap.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     pin_q <= 1'b0;
        else if (wrap_i) pin_q <= ~pin_q;
    end

    assign irq_o     = irq_q;
    assign clk_out_o = pin_q;

endmodule

// File: rtl/interval_timer.sv
// Basic interval timer top. Holds the active interval selection, which
// is loaded only by a mode write with the clear bit set, and wires the
// prescaler, counter, stabilization wait and output stage together.
module interval_timer
    import interval_timer_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned EXP0     = 13,
    parameter int unsigned EXP1     = 10,
    parameter int unsigned EXP2     = 8,
    parameter int unsigned EXP3     = 6,
    parameter int unsigned STAB_EXP = 9
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       mode_we_i,
    input  logic [1:0] mode_sel_i,
    input  logic       mode_clr_i,
    input  logic       irq_clr_i,
    output logic       irq_o,
    output logic       clk_out_o,
    output logic       cpu_run_o
);

    tap_sel_t         sel_q;
    logic             clr_w;
    logic             tick_w;
    logic             wrap_w;
    logic [CNT_W-1:0] cnt_w;

    // A clear takes effect only when written with the strobe.
    always_comb clr_w = mode_we_i && mode_clr_i;

    // Active selection register; new code loads with a clear write.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)    sel_q <= '0;
        else if (clr_w) sel_q <= tap_sel_t'(mode_sel_i);
    end

    interval_timer_presc #(
        .EXP0(EXP0), .EXP1(EXP1), .EXP2(EXP2), .EXP3(EXP3)
    ) presc_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_w),
        .sel_i  (sel_q),
        .tick_o (tick_w)
    );

    interval_timer_cnt #(
        .CNT_W(CNT_W)
    ) cnt_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_w),
        .tick_i (tick_w),
        .cnt_o  (cnt_w),
        .wrap_o (wrap_w)
    );

    interval_timer_stab #(
        .STAB_EXP(STAB_EXP), .CNT_W(CNT_W)
    ) stab_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_o  (cpu_run_o)
    );

    interval_timer_out out_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wrap_i    (wrap_w),
        .irq_clr_i (irq_clr_i),
        .irq_o     (irq_o),
        .clk_out_o (clk_out_o)
    );

endmodule

// File: rtl/interval_timer_chk.sv
// Property checker for the interval timer, bound into the top module.
// Observes ports plus the internal counter value and wrap event.
module interval_timer_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             mode_we_i,
    input logic             mode_clr_i,
    input logic             irq_clr_i,
    input logic             irq_o,
    input logic             clk_out_o,
    input logic             cpu_run_o,
    input logic [CNT_W-1:0] cnt_i,
    input logic             wrap_i
);

    // R1: reset drives the outputs low on the following edge.
    a_r1_reset_low: assert property (@(posedge clk_i)
        !rst_ni |=> (!irq_o && !clk_out_o && !cpu_run_o));

    // R4: a clear write leaves the counter at zero.
    a_r4_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_we_i && mode_clr_i) |=> (cnt_i == '0));

    // R5: the output pin only moves after a wrap.
    a_r5_toggle_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(clk_out_o) |-> $past(wrap_i));

    // R6: once high, the run enable stays high.
    a_r6_run_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_run_o |=> cpu_run_o);

    // R8: a clear with no wrap drops the flag.
    a_r8_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_clr_i && !wrap_i) |=> !irq_o);

    // R9: a wrap always leaves the flag set, clear or not.
    a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_i |=> irq_o);

    // R3: the flag rises only after a wrap.
    a_r3_rise_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(wrap_i));

endmodule

bind interval_timer interval_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_we_i  (mode_we_i),
    .mode_clr_i (mode_clr_i),
    .irq_clr_i  (irq_clr_i),
    .irq_o      (irq_o),
    .clk_out_o  (clk_out_o),
    .cpu_run_o  (cpu_run_o),
    .cnt_i      (cnt_w),
    .wrap_i     (wrap_w)
);

// File: tb/interval_timer_tb_top.sv
// Bench: directed phases plus seeded random stimulus, compared every
// cycle against a model that counts elapsed edges since reset or clear.
// Scaled tap exponents keep the run short.
module interval_timer_tb_top;

    localparam int unsigned E0 = 5, E1 = 4, E2 = 3, E3 = 2, SE = 3;
    localparam int unsigned STAB_CYC = 1 << (SE + 8);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       clr = 1'b0;
    logic       iclr = 1'b0;
    logic       irq, pin, run;

    int unsigned n_cmp = 0, n_bad = 0;
    string       tag = "R1";
    bit          done = 1'b0;

    // model state
    int unsigned m_since, m_sel, m_run_cnt;
    bit          m_irq, m_pin;

    interval_timer #(
        .CNT_W(8), .EXP0(E0), .EXP1(E1), .EXP2(E2), .EXP3(E3), .STAB_EXP(SE)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .mode_we_i(we), .mode_sel_i(sel),
        .mode_clr_i(clr), .irq_clr_i(iclr), .irq_o(irq), .clk_out_o(pin),
        .cpu_run_o(run)
    );

    always #4 clk = ~clk;

    // R2: interval length in clocks for a selection code.
    function automatic int unsigned period(input int unsigned code);
        int unsigned e;
        case (code)
            0: e = E0;
            1: e = E1;
            2: e = E2;
            default: e = E3;
        endcase
        return 256 << e;
    endfunction

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_since = 0; m_sel = 0; m_run_cnt = 0; m_irq = 0; m_pin = 0;
        end else begin
            if (m_run_cnt < STAB_CYC) m_run_cnt++;
            if (we && clr) begin
                m_since = 0;
                m_sel = sel;
                if (iclr) m_irq = 0;
            end else begin
                m_since++;
                if (m_since % period(m_sel) == 0) begin
                    m_irq = 1; m_pin = ~m_pin;
                end else if (iclr) m_irq = 0;
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s) t=%0t actual=%0b expected=%0b", req, tag, $time, act, exp);
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 irq", irq, m_irq);
            check("R5 pin", pin, m_pin);
            check("R6 run", run, m_run_cnt >= STAB_CYC);
        end
    end

    task automatic cyc(input int unsigned n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mode_wr(input logic [1:0] s, input logic c);
        @(negedge clk); we = 1; sel = s; clr = c;
        @(negedge clk); we = 0; clr = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++; n_cmp++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        cyc(5);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state directly after release.
        tag = "R1";
        check("R1 irq", irq, 1'b0);
        check("R1 pin", pin, 1'b0);
        check("R1 run", run, 1'b0);
        // R6: stabilization wait on the default code 0 run.
        tag = "R6";
        cyc(STAB_CYC + 20);
        check("R6 run high", run, 1'b1);
        // R2 / R4: each code from a clear, over two periods.
        for (int c = 0; c < 4; c++) begin
            tag = "R2 R4";
            mode_wr(2'(c), 1'b1);
            cyc(2 * period(c) + 40);
            @(negedge clk); iclr = 1; @(negedge clk); iclr = 0;
            tag = "R8";
            check("R8 irq cleared", irq, 1'b0);
        end
        // R7: write a faster code without the clear bit.
        tag = "R7";
        mode_wr(2'd0, 1'b1);
        cyc(300);
        mode_wr(2'd3, 1'b0);
        cyc(period(3) + 50);
        check("R7 no early irq", irq, 1'b0);
        cyc(period(0));
        // R9: interrupt clear held across wraps.
        tag = "R9";
        mode_wr(2'd3, 1'b1);
        iclr = 1;
        cyc(3 * period(3) + 7);
        iclr = 0;
        // Random mix.
        tag = "RND";
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            we  = ($urandom % 1500) == 0;
            clr = $urandom % 2;
            sel = 2'($urandom % 4);
            iclr = ($urandom % 97) == 0;
        end
        @(negedge clk); we = 0; clr = 0; iclr = 0;
        // R10: reset in mid-run restarts the wait.
        tag = "R10";
        rst_n = 0; cyc(3); rst_n = 1;
        @(negedge clk);
        check("R10 run low", run, 1'b0);
        cyc(STAB_CYC / 2);
        check("R10 still waiting", run, 1'b0);
        cyc(STAB_CYC);
        check("R10 run high", run, 1'b1);
        finish_run();
    end

endmodule